// File: doc/BRIEF.md
# Mixed-Policy External Request Detector

This block takes twelve asynchronous request lines: four dedicated request pins and eight key-scan lines. It brings each line into the clock domain and rejects pulses that are too short to be real requests. It then looks for the edge that each line is defined to respond to and records a sticky pending flag. Three of the pins are vectored sources. When one of them is pending and enabled, the block raises a request toward the processor and reports the number of the winning source. The fourth pin and all key-scan lines are quasi-interrupts: they only latch a flag, which software polls and clears.

Two pins have a trigger edge chosen by software. One pin responds to rising edges only. One pin responds to both edges. The key-scan lines respond to falling edges, because the keys idle high and are pulled low when pressed. The minimum pulse width is a count of clock cycles. For example, at a 4 MHz sampling clock, 40 cycles gives a 10 µs width.

Top module: `ext_irq_detect`

## Requirements
- R1: Every line passes through two synchronizing flops and a width filter. A level is accepted only after the synchronized line has held it for MIN_W consecutive clocks, and a pulse of MIN_W-1 clocks leaves no trace. An accepted change shows on the pending outputs MIN_W+2 rising edges after the input changes.
- R2: Pins 0 and 1 each have a two-bit edge select: 00 selects rising, 01 selects falling, and 1x selects both edges.
- R3: Pin 2 sets its flag on a rising edge only. It never raises the vectored request and never appears as an index.
- R4: Pin 3 sets its flag on both rising and falling edges and is a vectored source.
- R5: Each key-scan line sets its own flag on a falling edge only. Key flags never raise the vectored request.
- R6: A pending flag stays set until its clear strobe is high at a clock edge. If a new accepted edge arrives in the same cycle as the clear, the flag stays set.
- R7: irq_req is high exactly when a pending vectored source is enabled. irq_idx gives the lowest-numbered such source, encoded as 0, 1 or 3 (the pin number).
- R8: The enable bits (bit 0 for pin 0, bit 1 for pin 1, bit 2 for pin 3) gate only the request. Flags are set whatever the enables are.
- R9: After reset all flags are clear and irq_req is low. Synchronizers start at the idle levels: low for pins, high for keys.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | sampling clock |
| rst_n | input | 1 | active-low reset |
| pin_in | input | 4 | dedicated request pins |
| key_in | input | NKEY | key-scan lines, idle high |
| edge_sel0 | input | 2 | edge select for pin 0 |
| edge_sel1 | input | 2 | edge select for pin 1 |
| vec_en | input | 3 | enables for pins 0, 1, 3 |
| clr_pin | input | 4 | clear strobes for pin flags |
| clr_key | input | NKEY | clear strobes for key flags |
| irq_req | output | 1 | vectored request |
| irq_idx | output | 2 | winning vectored source number |
| pin_pend | output | 4 | pin pending flags |
| key_pend | output | NKEY | key pending flags |

## Verification
A filter counter stuck or off by one moves the moment a flag appears by a cycle, or lets a short pulse through. The flag outputs show this within MIN_W+2 clocks, so the bench samples at that exact edge and at one width below the limit. A wrong edge policy shows up as a flag that is missing or extra after one edge on a single line. A wrong priority or enable gating shows at irq_req/irq_idx in the same cycle, and the bench sweeps every pending-and-enable combination to catch it.

// File: rtl/ext_irq_detect.sv
module ext_irq_detect #(
  parameter int MIN_W = 40,
  parameter int NKEY  = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [3:0]      pin_in,
  input  logic [NKEY-1:0] key_in,
  input  logic [1:0]      edge_sel0,
  input  logic [1:0]      edge_sel1,
  input  logic [2:0]      vec_en,
  input  logic [3:0]      clr_pin,
  input  logic [NKEY-1:0] clr_key,
  output logic            irq_req,
  output logic [1:0]      irq_idx,
  output logic [3:0]      pin_pend,
  output logic [NKEY-1:0] key_pend
);
  localparam int N  = 4 + NKEY;
  localparam int CW = $clog2(MIN_W + 1);
  localparam logic [N-1:0] IDLE = {{NKEY{1'b1}}, 4'b0000};

  logic [N-1:0] s1, s2, lvl, chg, rise, fall;
  logic [3:0]   set_pin;
  logic [2:0]   vreq;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      s1 <= IDLE;
      s2 <= IDLE;
    end else begin
      s1 <= {key_in, pin_in};
      s2 <= s1;
    end

  for (genvar i = 0; i < N; i++) begin : g_filt
    logic [CW-1:0] cnt;
    logic          lv;
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        cnt <= '0;
        lv  <= IDLE[i];
      end else if (s2[i] == lv) begin
        cnt <= '0;
      end else if (cnt == CW'(MIN_W - 1)) begin
        cnt <= '0;
        lv  <= s2[i];
      end else begin
        cnt <= cnt + 1'b1;
      end
    assign lvl[i] = lv;
    assign chg[i] = (s2[i] != lv) && (cnt == CW'(MIN_W - 1));
  end

  assign rise = chg & s2;
  assign fall = chg & ~s2;

  function automatic logic hit(input logic [1:0] sel, input logic r, input logic f);
    return sel[1] ? (r | f) : (sel[0] ? f : r);
  endfunction

  assign set_pin[0] = hit(edge_sel0, rise[0], fall[0]);
  assign set_pin[1] = hit(edge_sel1, rise[1], fall[1]);
  assign set_pin[2] = rise[2];
  assign set_pin[3] = rise[3] | fall[3];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      pin_pend <= '0;
      key_pend <= '0;
    end else begin
      pin_pend <= (pin_pend & ~clr_pin) | set_pin;
      key_pend <= (key_pend & ~clr_key) | fall[N-1:4];
    end

  assign vreq    = {pin_pend[3], pin_pend[1], pin_pend[0]} & vec_en;
  assign irq_req = |vreq;
  assign irq_idx = vreq[0] ? 2'd0 : (vreq[1] ? 2'd1 : 2'd3);

  logic [N-1:0] pend_all, clr_all;
  assign pend_all = {key_pend, pin_pend};
  assign clr_all  = {clr_key, clr_pin};

  AST_SET_NEEDS_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend_all & ~$past(pend_all) & ~$past(chg)) == '0)); // R1
  AST_FLAG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(pend_all & ~clr_all) & ~pend_all) == '0)); // R6
  AST_QUASI_NO_INDEX: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> irq_idx != 2'd2); // R3
  AST_LOWEST_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req && irq_idx != 2'd0) |-> !(pin_pend[0] && vec_en[0])); // R7
  AST_REQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> vec_en != 3'b000); // R8
endmodule

// File: tb/tb_ext_irq_detect.sv
module tb_ext_irq_detect;
  localparam int CLK_PERIOD = 10;
  localparam int MW = 4;
  localparam int NK = 8;

  logic clk = 0, rst_n = 0;
  logic [3:0] pin_in = 4'b0000;
  logic [NK-1:0] key_in = '1;
  logic [1:0] edge_sel0 = 2'b00, edge_sel1 = 2'b00;
  logic [2:0] vec_en = 3'b000;
  logic [3:0] clr_pin = '0;
  logic [NK-1:0] clr_key = '0;
  logic irq_req;
  logic [1:0] irq_idx;
  logic [3:0] pin_pend;
  logic [NK-1:0] key_pend;

  int checks = 0, fails = 0;
  bit done = 0;

  ext_irq_detect #(.MIN_W(MW), .NKEY(NK)) dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic settle();
    repeat (MW + 4) @(negedge clk);
  endtask

  task automatic clear_all();
    @(negedge clk); clr_pin = '1; clr_key = '1;
    @(negedge clk); clr_pin = '0; clr_key = '0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    settle();
    chk(pin_pend == 0 && key_pend == 0, "R9 flags", {pin_pend, key_pend}, 0);
    chk(irq_req == 0, "R9 req", irq_req, 0);

    // R2: sweep all edge selects on pins 0 and 1
    for (int sel = 0; sel < 4; sel++) begin
      logic er, ef;
      er = (sel == 0) || sel[1];
      ef = (sel == 1) || sel[1];
      edge_sel0 = sel[1:0]; edge_sel1 = sel[1:0];
      clear_all();
      @(negedge clk); pin_in[1:0] = 2'b11; settle();
      chk(pin_pend[1:0] == {2{er}}, "R2 rise", pin_pend[1:0], {2{er}});
      clear_all();
      @(negedge clk); pin_in[1:0] = 2'b00; settle();
      chk(pin_pend[1:0] == {2{ef}}, "R2 fall", pin_pend[1:0], {2{ef}});
    end
    edge_sel0 = 2'b00; edge_sel1 = 2'b00;
    clear_all();

    // R3: pin 2 rising only, no vector
    vec_en = 3'b111;
    @(negedge clk); pin_in[2] = 1; settle();
    chk(pin_pend == 4'b0100, "R3 rise flag", pin_pend, 4'b0100);
    chk(irq_req == 0, "R3 no request", irq_req, 0);
    clear_all();
    @(negedge clk); pin_in[2] = 0; settle();
    chk(pin_pend == 4'b0000, "R3 fall ignored", pin_pend, 0);

    // R4: pin 3 both edges, vectored
    @(negedge clk); pin_in[3] = 1; settle();
    chk(pin_pend == 4'b1000, "R4 rise flag", pin_pend, 4'b1000);
    chk(irq_req == 1 && irq_idx == 3, "R4 vector", {irq_req, irq_idx}, 3'b111);
    clear_all();
    @(negedge clk); pin_in[3] = 0; settle();
    chk(pin_pend == 4'b1000, "R4 fall flag", pin_pend, 4'b1000);
    clear_all();

    // R5: each key line falling only
    for (int i = 0; i < NK; i++) begin
      @(negedge clk); key_in[i] = 0; settle();
      chk(key_pend == (NK'(1) << i), "R5 fall", key_pend, NK'(1) << i);
      chk(irq_req == 0, "R5 no request", irq_req, 0);
      clear_all();
      @(negedge clk); key_in[i] = 1; settle();
      chk(key_pend == 0, "R5 rise ignored", key_pend, 0);
    end

    // R1: width filter boundary
    @(negedge clk); pin_in[3] = 1;
    repeat (MW - 1) @(negedge clk);
    pin_in[3] = 0; settle();
    chk(pin_pend[3] == 0, "R1 short pulse", pin_pend[3], 0);
    @(negedge clk); key_in[0] = 0;
    repeat (MW - 1) @(negedge clk);
    key_in[0] = 1; settle();
    chk(key_pend == 0, "R1 short key pulse", key_pend, 0);
    @(negedge clk); pin_in[3] = 1;
    repeat (MW) @(negedge clk);
    pin_in[3] = 0; settle();
    chk(pin_pend[3] == 1, "R1 full pulse", pin_pend[3], 1);
    clear_all();

    // R1 latency and R6 set wins over clear
    @(negedge clk); pin_in[3] = 1;
    repeat (MW + 1) @(posedge clk);
    @(negedge clk);
    chk(pin_pend[3] == 0, "R1 not before latency", pin_pend[3], 0);
    clr_pin = 4'b1000;
    @(negedge clk); clr_pin = 0;
    chk(pin_pend[3] == 1, "R6 set beats clear", pin_pend[3], 1);
    repeat (3) @(negedge clk);
    chk(pin_pend[3] == 1, "R6 holds", pin_pend[3], 1);
    clear_all();
    chk(pin_pend[3] == 0, "R6 clear", pin_pend[3], 0);
    @(negedge clk); pin_in[3] = 0; settle();
    clear_all();

    // R7/R8: all pending and enable combinations
    vec_en = 0;
    for (int p = 0; p < 8; p++) begin
      logic [3:0] ep;
      ep = {p[2], 1'b0, p[1], p[0]};
      @(negedge clk); pin_in = ep; settle();
      chk(pin_pend == ep, "R8 flags without enable", pin_pend, ep);
      for (int e = 0; e < 8; e++) begin
        logic [2:0] m;
        logic [1:0] xi;
        m = p[2:0] & e[2:0];
        xi = m[0] ? 2'd0 : (m[1] ? 2'd1 : 2'd3);
        @(negedge clk); vec_en = e[2:0]; #1;
        chk(irq_req == (m != 0), "R7 request", irq_req, m != 0);
        if (m != 0) chk(irq_idx == xi, "R7 index", irq_idx, xi);
      end
      @(negedge clk); vec_en = 0; pin_in = 0; settle();
      clear_all();
    end

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule